// File: doc/BRIEF.md
# Tagged Sample Buffer with Half-Full Interrupt

This block is the elastic store between an analog scan controller and a byte-wide host bus. Each conversion result arrives as one 16-bit word: a 4-bit channel tag in bits 3:0 and a 12-bit sample in bits 15:4. While capture is switched on, the block keeps these words in first-in, first-out order, 1024 of them by default.

When the buffer becomes half full, the block raises an interrupt. The host then removes a burst of half the depth, one byte at a time. It reads the low byte through one strobe, which shows the head word without taking it. It then reads the high byte through a second strobe, which takes the word off the buffer. Dedicated strobes switch capture on or off, drop the interrupt and empty the buffer. A 3-bit status output reports empty, half-full and a sticky overflow flag. Address decoding on the host bus and the converter itself sit outside the block.

Top module: `tagfifo`

## Requirements
- R1: Words leave in the order they were accepted, with every bit unchanged: the tag in bits 3:0 and the sample in bits 15:4.
- R2: A word offered on `cap_valid` is stored only while capture is on. A strobe on `en_we` with `en_bit`=1 turns capture on, and one with `en_bit`=0 turns it off. A word offered while capture is off leaves the status unchanged.
- R3: `status` bit 0 is 1 when the fill level is zero. Bit 1 is 1 when the fill level is at least DEPTH/2. Bit 2 is the overflow flag. Each bit follows the clock edge that changes the fill level.
- R4: When the half-full condition rises, `irq` goes high one clock later.
- R5: A strobe on `irq_clr_we` drops `irq` at the next edge. Afterwards `irq` stays low while the buffer remains half full, and it rises again only on a new rising edge of the half-full condition.
- R6: A word offered while capture is on and the buffer is full, with no pop in the same cycle, is discarded. The same edge sets the overflow flag and raises `irq`. The flag stays set through reads and interrupt clears.
- R7: A strobe on `flush_we` empties the buffer and clears the overflow flag at the next edge. Words accepted afterwards are read back normally.
- R8: A `lo_rd` strobe puts the head word's bits 7:0 on `rd_byte` at the next edge and removes nothing. A `hi_rd` strobe puts bits 15:8 on `rd_byte` and removes the head word.
- R9: A read from an empty buffer returns the matching byte of the last word removed and leaves the pointers unchanged, so the next word stored is the next word read.
- R10: After reset the buffer is empty, capture is off, `status` is 3'b001, `irq` is 0 and `rd_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | A conversion word is offered this cycle |
| cap_word | input | 16 | Conversion word: tag in 3:0, sample in 15:4 |
| en_we | input | 1 | Write strobe for the capture enable |
| en_bit | input | 1 | Value written with en_we: 1 turns capture on, 0 turns it off |
| irq_clr_we | input | 1 | Interrupt clear strobe; the data written is ignored |
| flush_we | input | 1 | Flush strobe; the data written is ignored |
| lo_rd | input | 1 | Read strobe for the low byte of the head word |
| hi_rd | input | 1 | Read strobe for the high byte; removes the head word |
| rd_byte | output | 8 | Registered byte returned by the last read strobe |
| status | output | 3 | {overflow, half-full, empty} |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with ADDR_W=4, which gives 16 entries and a half-full threshold of 8. With that setting one sweep fills the buffer one word at a time and checks the status, and then drains it checking every byte. This covers each fill level, both half-full transitions, the full-buffer drop and the overflow flag in a few hundred cycles. Each word is derived arithmetically from its index, and its tag equals the index mod 16, so every tag value passes through. The bench also covers empty reads, a flush in the middle of a fill, and the interrupt re-arming after a clear.

// File: rtl/tagfifo_pkg.sv
package tagfifo_pkg;
  localparam int TAG_W    = 4;
  localparam int SAMPLE_W = 12;
  localparam int WORD_W   = TAG_W + SAMPLE_W;
  localparam int BYTE_W   = 8;
  // status bit positions, decoded by host software
  localparam int ST_EMPTY = 0;
  localparam int ST_HALF  = 1;
  localparam int ST_OVF   = 2;
  localparam int ST_W     = 3;
endpackage

// File: rtl/tagfifo_ram.sv
module tagfifo_ram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/tagfifo_ctrl.sv
module tagfifo_ctrl #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic [DW-1:0] push_word,
  input  logic          pop_req,
  input  logic          flush,
  output logic [DW-1:0] head_word,
  output logic [AW:0]   level,
  output logic          empty,
  output logic          half,
  output logic          ovf,
  output logic          ovf_evt,
  output logic          pop
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;

  logic [AW-1:0] wr_ptr_q, rd_ptr_q, rd_addr;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          full, push;
  logic          byp_sel_q;
  logic [DW-1:0] byp_q, ram_q;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign half    = (cnt_q >= CW'(DEPTH / 2));
  assign pop     = pop_req & ~empty & ~flush;
  assign push    = push_req & (~full | pop) & ~flush;
  assign ovf_evt = push_req & full & ~pop & ~flush;

  // address the RAM with the head that will be valid after this edge
  always_comb begin
    if (flush)    rd_addr = '0;
    else if (pop) rd_addr = rd_ptr_q + AW'(1);
    else          rd_addr = rd_ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (ovf_evt) ovf_q <= 1'b1;
    end
  end

  // a write landing on the address being read this edge is forwarded
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_sel_q <= 1'b0;
      byp_q     <= '0;
    end else begin
      byp_sel_q <= push && (wr_ptr_q == rd_addr);
      byp_q     <= push_word;
    end
  end

  tagfifo_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (push),
    .waddr (wr_ptr_q),
    .wdata (push_word),
    .raddr (rd_addr),
    .q     (ram_q)
  );

  assign head_word = byp_sel_q ? byp_q : ram_q;
  assign level     = cnt_q;
  assign ovf       = ovf_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !flush) |=> ovf_q); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push_req && full && !pop_req && !flush) |=> (full && ovf_q)); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && !ovf_q)); // R7
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_req && !push_req && !flush) |=> ($stable(rd_ptr_q) && empty)); // R9
endmodule

// File: rtl/tagfifo_irq.sv
module tagfifo_irq (
  input  logic clk,
  input  logic rst,
  input  logic half,
  input  logic ovf_evt,
  input  logic clr,
  output logic irq
);
  logic half_d_q, irq_q, half_rise;

  assign half_rise = half & ~half_d_q;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      half_d_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      half_d_q <= half;
      if (half_rise || ovf_evt) irq_q <= 1'b1;
      else if (clr)             irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;

  AST_IRQ_ON_HALF: assert property (@(posedge clk) disable iff (rst)
    $rose(half) |=> irq_q); // R4
  AST_IRQ_ON_OVF: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> irq_q); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr && !half_rise && !ovf_evt) |=> !irq_q); // R5
endmodule

// File: rtl/tagfifo.sv
module tagfifo
  import tagfifo_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_valid,
  input  logic [WORD_W-1:0] cap_word,
  input  logic              en_we,
  input  logic              en_bit,
  input  logic              irq_clr_we,
  input  logic              flush_we,
  input  logic              lo_rd,
  input  logic              hi_rd,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [ST_W-1:0]   status,
  output logic              irq
);
  logic              cap_en_q;
  logic [WORD_W-1:0] head_word, last_q, src_word;
  logic [ADDR_W:0]   level;
  logic              empty, half, ovf, ovf_evt, pop;
  logic [BYTE_W-1:0] rd_byte_q;

  always_ff @(posedge clk) begin
    if (rst)         cap_en_q <= 1'b0;
    else if (en_we)  cap_en_q <= en_bit;
  end

  tagfifo_ctrl #(.AW(ADDR_W), .DW(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .push_req  (cap_valid & cap_en_q),
    .push_word (cap_word),
    .pop_req   (hi_rd),
    .flush     (flush_we),
    .head_word (head_word),
    .level     (level),
    .empty     (empty),
    .half      (half),
    .ovf       (ovf),
    .ovf_evt   (ovf_evt),
    .pop       (pop)
  );

  tagfifo_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .half    (half),
    .ovf_evt (ovf_evt),
    .clr     (irq_clr_we),
    .irq     (irq)
  );

  // an empty buffer answers with the last word removed
  assign src_word = empty ? last_q : head_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q    <= '0;
      rd_byte_q <= '0;
    end else begin
      if (pop) last_q <= head_word;
      if (hi_rd)      rd_byte_q <= src_word[WORD_W-1:BYTE_W];
      else if (lo_rd) rd_byte_q <= src_word[BYTE_W-1:0];
    end
  end

  assign rd_byte = rd_byte_q;

  always_comb begin
    status           = '0;
    status[ST_EMPTY] = empty;
    status[ST_HALF]  = half;
    status[ST_OVF]   = ovf;
  end

  AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!cap_en_q && !hi_rd && !flush_we) |=> $stable(level)); // R2
  AST_POP_ONLY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (lo_rd && !hi_rd && !cap_valid && !flush_we) |=> $stable(level)); // R8
endmodule

// File: tb/tagfifo_bench.sv
module tagfifo_bench;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_valid = 0, en_we = 0, en_bit = 0, irq_clr_we = 0;
  logic        flush_we = 0, lo_rd = 0, hi_rd = 0;
  logic [15:0] cap_word = '0;
  logic [7:0]  rd_byte;
  logic [2:0]  status;
  logic        irq;

  int vecs = 0;
  int bad  = 0;
  bit done = 0;

  // reference model state
  logic [15:0] mq [DEPTH];
  int          mh = 0, mc = 0;
  bit          men = 0, movf = 0;
  logic [15:0] mlast = '0;

  always #4 clk = ~clk;

  tagfifo #(.ADDR_W(AW)) u_tagfifo (
    .clk, .rst, .cap_valid, .cap_word, .en_we, .en_bit, .irq_clr_we,
    .flush_we, .lo_rd, .hi_rd, .rd_byte, .status, .irq
  );

  function automatic logic [15:0] wf(input int i);
    return {12'(i * 149 + 7), 4'(i)};
  endfunction

  function automatic logic [2:0] exp_st();
    return {movf, (mc >= DEPTH / 2), (mc == 0)};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_st(input string req);
    chk(req, {13'b0, status}, {13'b0, exp_st()});
  endtask

  task automatic push(input int idx);
    cap_valid = 1; cap_word = wf(idx);
    @(negedge clk);
    cap_valid = 0;
    if (men) begin
      if (mc < DEPTH) begin mq[(mh + mc) % DEPTH] = wf(idx); mc++; end
      else movf = 1;
    end
  endtask

  task automatic set_en(input bit v);
    en_we = 1; en_bit = v;
    @(negedge clk);
    en_we = 0; men = v;
  endtask

  task automatic clr_irq();
    irq_clr_we = 1;
    @(negedge clk);
    irq_clr_we = 0;
  endtask

  task automatic do_flush();
    flush_we = 1;
    @(negedge clk);
    flush_we = 0; mc = 0; mh = 0; movf = 0;
  endtask

  task automatic rd_lo(input string req);
    logic [7:0] e;
    lo_rd = 1;
    @(negedge clk);
    lo_rd = 0;
    e = (mc == 0) ? mlast[7:0] : mq[mh][7:0];
    chk(req, {8'b0, rd_byte}, {8'b0, e});
  endtask

  task automatic rd_hi(input string req);
    logic [7:0] e;
    hi_rd = 1;
    @(negedge clk);
    hi_rd = 0;
    e = (mc == 0) ? mlast[15:8] : mq[mh][15:8];
    chk(req, {8'b0, rd_byte}, {8'b0, e});
    if (mc > 0) begin mlast = mq[mh]; mh = (mh + 1) % DEPTH; mc--; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    // R10 reset state
    chk("R10", {13'b0, status}, 16'h0001);
    chk("R10", {15'b0, irq}, 16'h0);
    chk("R10", {8'b0, rd_byte}, 16'h0);

    // R2 capture off: word ignored
    push(100);
    chk_st("R2");
    set_en(1);

    // R3 / R4 fill sweep
    for (int n = 0; n < DEPTH; n++) begin
      push(n);
      chk_st("R3");
      chk("R4", {15'b0, irq}, {15'b0, (mc >= DEPTH / 2 + 1)});
    end
    idle(1);
    chk("R4", {15'b0, irq}, 16'h1);

    // R5 clear holds while still half full
    clr_irq();
    chk("R5", {15'b0, irq}, 16'h0);
    idle(3);
    chk("R5", {15'b0, irq}, 16'h0);

    // R6 overflow drop
    push(DEPTH);
    chk_st("R6");
    chk("R6", {15'b0, irq}, 16'h1);
    clr_irq();
    chk("R6", {15'b0, irq}, 16'h0);
    chk_st("R6");

    // R2 capture off again
    set_en(0);
    push(50);
    chk_st("R2");

    // R1 / R8 drain sweep, overflow stays set
    for (int i = 0; i < DEPTH; i++) begin
      rd_lo("R8");
      rd_lo("R8");
      rd_hi("R1");
      chk_st("R6");
    end

    // R9 empty reads
    rd_lo("R9");
    rd_hi("R9");
    chk_st("R9");

    // R7 flush clears overflow
    do_flush();
    chk_st("R7");

    // R9 pointers intact after empty read
    set_en(1);
    for (int i = 20; i < 23; i++) push(i);
    for (int i = 0; i < 3; i++) begin rd_lo("R9"); rd_hi("R9"); end

    // R7 flush mid-fill
    for (int i = 23; i < 27; i++) push(i);
    do_flush();
    chk_st("R7");
    push(30);
    rd_lo("R7");
    rd_hi("R7");
    chk_st("R7");

    // R5 re-arm on new rising edge
    chk("R5", {15'b0, irq}, 16'h0);
    for (int i = 40; i < 40 + DEPTH / 2; i++) push(i);
    idle(1);
    chk("R4", {15'b0, irq}, 16'h1);
    clr_irq();
    rd_hi("R8");
    idle(1);
    chk("R5", {15'b0, irq}, 16'h0);
    push(60);
    idle(1);
    chk("R5", {15'b0, irq}, 16'h1);
    chk_st("R3");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule